// File: doc/BRIEF.md
# Link-Up Monitor with Receive-Reset Recovery

This block watches the status of a serial link's training logic and decides when the link is usable. It receives two 32-bit debug words from the training logic. A registered `link_up` flag follows the "link up" bit of debug word 1, but only when that word's "training in progress" bit is clear.

A `start` strobe begins a bring-up run, which is a series of polling attempts. Each attempt first waits a settling window. If the link is up after that window, the run ends. If not, the block uses an external PHY register access engine to read the receive status register. A speed change is treated as stuck when the training state in debug word 0 is the receiver-lock recovery code and the receive-valid bit is low. In that case the block pulses the receiver's data and PLL override enables. It does this as a read-modify-write of the override register, which sets the two bits, waits a hold window, and then clears them again.

When a configured number of attempts pass without the link coming up, `link_fail` rises. It stays high until the next start.

Top module: `link_watch`

## Requirements
- R1: `link_up` equals, one cycle later, the value of dbg1[4] AND NOT dbg1[29] sampled at the clock edge. It is 0 out of reset.
- R2: After an accepted `start`, the block waits SETTLE_CYC cycles and then evaluates dbg1 in one check cycle. If the link is up, the run ends with no access request.
- R3: If the link is not up in the check cycle, the block issues one read request (`req_wr`=0) to address 0x100D.
- R4: The speed change is stuck when dbg0[5:0] equals STUCK_CODE (default 6'h0D) and bit 0 of the read data from 0x100D is 0. Any other result goes straight to the end of the attempt with no further request.
- R5: When stuck, the block reads 0x1005 and then writes back the read value with bits 5 and 3 set (OR 16'h0028).
- R6: After that write completes, the block issues no request for HOLD_CYC cycles. It then reads 0x1005 again and writes back the read value with bits 5 and 3 cleared.
- R7: A request holds `req_valid`, `req_wr`, `req_addr` and `req_wdata` steady until the cycle in which `req_ack` is high. Read data is taken in that same cycle.
- R8: Each attempt without link-up costs one extra cycle at its end. After MAX_TRIES such attempts, `link_fail` goes to 1 and the run stops with no further requests.
- R9: `link_fail` stays 1 until an accepted `start`, which clears it in the same edge.
- R10: A `start` that arrives while a run is in progress has no effect.
- R11: Only one recovery runs at a time. Changes to dbg0 or to the receive status during a recovery do not alter its request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a bring-up run when idle |
| dbg0 | input | 32 | Debug word 0; bits [5:0] hold the training state |
| dbg1 | input | 32 | Debug word 1; bit 4 link up, bit 29 training in progress |
| link_up | output | 1 | Registered link-usable flag |
| link_fail | output | 1 | Attempt limit reached without link-up |
| req_valid | output | 1 | PHY register access request |
| req_wr | output | 1 | 1 for write, 0 for read |
| req_addr | output | 16 | PHY register address |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | Access completes in this cycle |
| req_rdata | input | 16 | Read data, valid with `req_ack` |

## Verification
The bench tries the bring-up run with the link already up, with the link reporting up while still training, and with a training state other than the recovery code. It also tries the recovery code with receive-valid high and with it low. Together these separate the link-up decision from the stuck decision, and separate the stuck decision's two conditions. The recovery case runs with an access engine that answers at once and with one that answers late, so that request holding and the read-modify-write values are both exposed. The exhaustion case, with a start pulse during the run, distinguishes the attempt count, the sticky failure flag and the ignored start.

// File: rtl/link_watch.sv
module link_watch #(
  parameter int          SETTLE_CYC = 100000,
  parameter int          HOLD_CYC   = 50000,
  parameter int          MAX_TRIES  = 10,
  parameter logic [5:0]  STUCK_CODE = 6'h0D,
  parameter logic [15:0] STAT_ADDR  = 16'h100D,
  parameter logic [15:0] OVRD_ADDR  = 16'h1005,
  parameter logic [15:0] OVRD_MASK  = 16'h0028
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dbg0,
  input  logic [31:0] dbg1,
  output logic        link_up,
  output logic        link_fail,
  output logic        req_valid,
  output logic        req_wr,
  output logic [15:0] req_addr,
  output logic [15:0] req_wdata,
  input  logic        req_ack,
  input  logic [15:0] req_rdata
);
  localparam int CMAX = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(MAX_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_CHK, S_STAT, S_RD1, S_WR1, S_HOLD, S_RD2, S_WR2, S_NEXT
  } st_t;

  st_t            st_q;
  logic [CW-1:0]  cnt_q;
  logic [TW-1:0]  tries_q;
  logic [15:0]    wd_q;

  wire up_now = dbg1[4] & ~dbg1[29];
  wire stuck  = (dbg0[5:0] == STUCK_CODE) & ~req_rdata[0];
  wire unused_dbg = ^{dbg0[31:6], dbg1[31:30], dbg1[28:5], dbg1[3:0]};

  assign req_valid = (st_q == S_STAT) | (st_q == S_RD1) | (st_q == S_WR1) |
                     (st_q == S_RD2)  | (st_q == S_WR2);
  assign req_wr    = (st_q == S_WR1) | (st_q == S_WR2);
  assign req_addr  = (st_q == S_STAT) ? STAT_ADDR : OVRD_ADDR;
  assign req_wdata = req_wr ? wd_q : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_up <= 1'b0;
    else        link_up <= up_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      tries_q   <= '0;
      wd_q      <= '0;
      link_fail <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q      <= S_WAIT;
          cnt_q     <= '0;
          tries_q   <= '0;
          link_fail <= 1'b0;
        end
        S_WAIT: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) st_q <= S_CHK;
          cnt_q <= (cnt_q == CW'(SETTLE_CYC - 1)) ? '0 : cnt_q + 1'b1;
        end
        S_CHK:  st_q <= up_now ? S_IDLE : S_STAT;
        S_STAT: if (req_ack) st_q <= stuck ? S_RD1 : S_NEXT;
        S_RD1:  if (req_ack) begin
          wd_q <= req_rdata | OVRD_MASK;
          st_q <= S_WR1;
        end
        S_WR1:  if (req_ack) begin
          st_q  <= S_HOLD;
          cnt_q <= '0;
        end
        S_HOLD: begin
          if (cnt_q == CW'(HOLD_CYC - 1)) st_q <= S_RD2;
          cnt_q <= (cnt_q == CW'(HOLD_CYC - 1)) ? '0 : cnt_q + 1'b1;
        end
        S_RD2:  if (req_ack) begin
          wd_q <= req_rdata & ~OVRD_MASK;
          st_q <= S_WR2;
        end
        S_WR2:  if (req_ack) st_q <= S_NEXT;
        S_NEXT: begin
          cnt_q <= '0;
          if (tries_q == TW'(MAX_TRIES - 1)) begin
            link_fail <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            tries_q <= tries_q + 1'b1;
            st_q    <= S_WAIT;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module link_watch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] dbg1,
  input logic        link_up,
  input logic        link_fail,
  input logic        req_valid,
  input logic        req_wr,
  input logic [15:0] req_addr,
  input logic [15:0] req_wdata,
  input logic        req_ack
);
  p_link_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (link_up == ($past(dbg1[4]) && !$past(dbg1[29]))));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_wr) &&
                                 $stable(req_addr) && $stable(req_wdata)));

  p_addr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr == 16'h100D || req_addr == 16'h1005));

  p_write_ovrd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr) |-> (req_addr == 16'h1005));

  p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> !req_valid);

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && !start) |=> link_fail);
endmodule

bind link_watch link_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dbg1(dbg1),
  .link_up(link_up), .link_fail(link_fail), .req_valid(req_valid),
  .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_ack(req_ack)
);

// File: tb/link_watch_bench.sv
module link_watch_bench;
  localparam int SETTLE = 8;
  localparam int HOLD   = 5;
  localparam int TRIES  = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] dbg0 = 0, dbg1 = 0;
  logic link_up, link_fail, req_valid, req_wr, req_ack = 0;
  logic [15:0] req_addr, req_wdata, req_rdata = 0;

  link_watch #(.SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD), .MAX_TRIES(TRIES)) u_link_watch (
    .clk(clk), .rst_n(rst_n), .start(start), .dbg0(dbg0), .dbg1(dbg1),
    .link_up(link_up), .link_fail(link_fail), .req_valid(req_valid),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_rdata(req_rdata));

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic e_up = 0, e_fail = 0, e_valid = 0, e_wr = 0, model_busy = 0;
  logic [15:0] e_addr = 0, e_wdata = 0;
  logic [15:0] rx_asic = 16'h0001, phy_ovrd = 16'h1234;
  int resp_lat = 0, wcnt = 0, phy_writes = 0;

  task automatic step; @(posedge clk); #1; endtask
  task automatic expect_req(input logic v, input logic w, input logic [15:0] a, input logic [15:0] d);
    e_valid = v; e_wr = w; e_addr = a; e_wdata = d;
  endtask
  task automatic wait_ack; do step(); while (!req_ack); endtask

  always @(posedge clk) begin
    #1;
    e_up = rst_n ? (dbg1[4] & ~dbg1[29]) : 1'b0;
  end

  initial begin : model
    logic [15:0] v;
    int tries;
    wait (rst_n);
    forever begin
      step();
      if (start) begin
        model_busy = 1; e_fail = 0; tries = 0;
        forever begin
          repeat (SETTLE) step();
          step();
          if (dbg1[4] && !dbg1[29]) break;
          expect_req(1, 0, 16'h100D, 0);
          wait_ack();
          if (dbg0[5:0] == 6'h0D && !req_rdata[0]) begin
            expect_req(1, 0, 16'h1005, 0);
            wait_ack();
            v = req_rdata | 16'h0028;
            expect_req(1, 1, 16'h1005, v);
            wait_ack();
            expect_req(0, 0, 0, 0);
            repeat (HOLD) step();
            expect_req(1, 0, 16'h1005, 0);
            wait_ack();
            v = req_rdata & ~16'h0028;
            expect_req(1, 1, 16'h1005, v);
            wait_ack();
          end
          expect_req(0, 0, 0, 0);
          step();
          tries++;
          if (tries == TRIES) begin e_fail = 1; break; end
        end
        model_busy = 0;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    cycles++;
    vectors++;
    if (link_up !== e_up || link_fail !== e_fail || req_valid !== e_valid ||
        (e_valid && (req_wr !== e_wr || req_addr !== e_addr)) ||
        (e_valid && e_wr && req_wdata !== e_wdata)) begin
      miscompares++;
      if (link_up !== e_up) $display("FAIL R1 link_up got %0b exp %0b", link_up, e_up);
      if (link_fail !== e_fail) $display("FAIL R8/R9 link_fail got %0b exp %0b", link_fail, e_fail);
      if (req_valid !== e_valid) $display("FAIL R2/R3/R6 req_valid got %0b exp %0b", req_valid, e_valid);
      if (e_valid && (req_wr !== e_wr || req_addr !== e_addr))
        $display("FAIL R5/R7 wr/addr got %0b/%h exp %0b/%h", req_wr, req_addr, e_wr, e_addr);
      if (e_valid && e_wr && req_wdata !== e_wdata)
        $display("FAIL R5/R6 wdata got %h exp %h", req_wdata, e_wdata);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin req_ack = 0; wcnt = 0; end
    else if (req_ack) begin req_ack = 0; wcnt = 0; end
    else if (req_valid) begin
      if (wcnt >= resp_lat) begin
        req_ack = 1;
        req_rdata = (req_addr == 16'h100D) ? rx_asic : phy_ovrd;
        if (req_wr) begin phy_ovrd = req_wdata; phy_writes++; end
      end else wcnt++;
    end
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run;
    pulse_start();
    wait (model_busy);
    wait (!model_busy);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset link_up", {15'd0, link_up}, 16'd0);
    check("R8 reset link_fail", {15'd0, link_fail}, 16'd0);
    rst_n = 1;
    // R1/R2: link up already, and up-while-training
    dbg1 = 32'h0000_0010;
    run();
    dbg1 = 32'h2000_0010;
    repeat (3) @(negedge clk);
    check("R1 training masks up", {15'd0, link_up}, 16'd0);
    // R3/R4/R8/R10: other state, exhaust attempts, start mid-run
    dbg1 = 0; dbg0 = 32'h11; rx_asic = 16'h0000; resp_lat = 1;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    wait (!model_busy);
    repeat (6) @(negedge clk);
    check("R9 fail sticky", {15'd0, link_fail}, 16'd1);
    check("R4 no recovery writes", phy_writes[15:0], 16'd0);
    // R4: recovery code but receive valid high
    dbg0 = 32'h0D; rx_asic = 16'h0001;
    run();
    check("R4 valid blocks recovery", phy_writes[15:0], 16'd0);
    // R5/R6/R11: stuck, fast engine, then link comes up
    rx_asic = 16'h0000; resp_lat = 0; phy_ovrd = 16'h1234;
    pulse_start();
    wait (phy_writes == 1);
    @(negedge clk);
    check("R5 override set", phy_ovrd, 16'h123C);
    dbg0 = 32'h02; rx_asic = 16'h0001;
    wait (phy_writes == 2);
    @(negedge clk);
    check("R6 override cleared", phy_ovrd, 16'h1214);
    dbg1 = 32'h10;
    wait (!model_busy);
    repeat (4) @(negedge clk);
    check("R2 up ends run", {14'd0, link_up, link_fail}, 16'd2);
    // R5/R7: stuck again with slow engine
    dbg1 = 0; dbg0 = 32'h0D; rx_asic = 16'h0000; resp_lat = 3; phy_ovrd = 16'hFFFF;
    run();
    check("R6 all-ones cleared", phy_ovrd, 16'hFFD7);
    check("R8 fail after recoveries", {15'd0, link_fail}, 16'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule